// File: doc/BRIEF.md
# Configurable TDM Multiplex Slot Interface

This block is the system-side serial port of a line controller. It receives a serial multiplex on one input line and drives a serial multiplex on one output line. Both run from the block clock, which stands for the local multiplex clock, and a frame sync pulse aligns them. It keeps the bit and time-slot counters for the frame. It decides which time slots belong to this device. It turns each owned received slot into a parallel word, and it serialises a parallel word into each owned transmit slot.

A small configuration register sets the behaviour. Three rate bits choose a multiplex of 32, 64 or 128 time slots. In the two larger multiplexes the device owns an interleaved subset of exactly 32 slots. A double-clock bit makes each bit period last two clocks, and received data is then sampled on the second clock of the period. A high-impedance bit releases the output line. The register resets to 0x80, so the output is released until software writes it. Upstream logic reads the local slot index output and presents the matching transmit word.

Top module: `tdm_mux_port`

## Requirements
- R1: After reset the configuration register holds 0x80. Its fields are bit 7 = output release, bit 3 = double clock, bits 2:0 = rate bits {m2,m1,m0}. After reset, bit_cnt = 0, slot_cnt = 0, rx_valid = 0 and mux_oe = 0.
- R2: With m2 = 0 and m1 = 0 the frame has 32 slots. Every slot is selected, slot_cnt wraps from 31 to 0, and the local index equals slot_cnt.
- R3: With m2 = 0 and m1 = 1 the frame has 64 slots and slot_cnt wraps from 63 to 0. A slot is selected when slot_cnt bit 0 equals m0, and its local index is slot_cnt / 2.
- R4: With m2 = 1 the frame has 128 slots and slot_cnt wraps from 127 to 0. A slot is selected when slot_cnt mod 4 equals {m1,m0}, and its local index is slot_cnt / 4.
- R5: With the double-clock bit clear, a bit period is one clock and bit_cnt advances on every clock. With it set, a bit period is two clocks and the input is sampled on the second of them.
- R6: A frame sync sampled high forces bit 0 of slot 0, first clock of the bit period, on the next clock. No input bit is sampled on that edge.
- R7: Received bits are assembled MSB first. After the eighth sampled bit of a selected slot, rx_valid is high for exactly one clock, with rx_word and rx_slot (local index 0 to 31) valid.
- R8: In unselected slots mux_oe is 0, no input bit is taken, and rx_valid stays 0.
- R9: While the output release bit is set, mux_oe is 0 and mux_out is high impedance, whatever the other settings are.
- R10: In a selected slot with the release bit clear, mux_oe is 1 and mux_out carries tx_word bit (7 - bit_cnt), MSB first. tx_slot gives the local index of the current slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local multiplex clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| fsync | input | 1 | Frame sync, active high for one clock |
| mux_in | input | 1 | Serial multiplex input |
| tx_word | input | 8 | Word to send in the current selected slot |
| mux_out | output | 1 | Serial multiplex output, high impedance when not driven |
| mux_oe | output | 1 | Output drive enable |
| slot_sel | output | 1 | Current slot belongs to this device |
| tx_slot | output | 5 | Local index of the current slot |
| bit_cnt | output | 3 | Bit position within the current slot |
| slot_cnt | output | 7 | Time slot number within the frame |
| rx_word | output | 8 | Assembled received word |
| rx_valid | output | 1 | One-clock strobe for rx_word |
| rx_slot | output | 5 | Local index of the received word |

## Verification
The assertions take three things for granted. Frame sync pulses last one clock. Configuration writes change the rate only where a frame sync follows before the next slot boundary, so slot_cnt never starts beyond the new frame length. tx_word is held steady while a slot is being sent. The bench changes the configuration only in a write followed at once by a frame sync. It updates tx_word only between clock edges, and it pulses frame sync both at frame boundaries and in the middle of a slot to exercise realignment.

// File: rtl/tdm_pkg.sv
// Package: shared types and constants for the TDM multiplex port.
// Assumes an 8-bit configuration register with fixed field positions.
package tdm_pkg;

    // Multiplex rate relative to the base 32-slot frame
    typedef enum logic [1:0] {
        RATE_X1 = 2'd0,
        RATE_X2 = 2'd1,
        RATE_X4 = 2'd2
    } rate_e;

    // Configuration register layout
    typedef struct packed {
        logic       out_rel;   // release output line
        logic [2:0] spare;
        logic       dbl_clk;   // two clocks per bit
        logic [2:0] rate_bits; // {m2,m1,m0}
    } port_cfg_t;

    localparam logic [7:0] CFG_RESET = 8'h80;

    // Map rate bits to a multiplex rate
    function automatic rate_e decode_rate(input logic [2:0] m);
        if (m[2])      return RATE_X4;
        else if (m[1]) return RATE_X2;
        else           return RATE_X1;
    endfunction

endpackage

// File: rtl/tdm_cfg_reg.sv
// Module: configuration register of the multiplex port.
// Holds rate, double-clock and output-release fields; resets to CFG_RESET.
module tdm_cfg_reg
    import tdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output port_cfg_t  cfg
);

    // Register write with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg <= port_cfg_t'(CFG_RESET);
        else if (we) cfg <= port_cfg_t'(wdata);
    end

endmodule

// File: rtl/tdm_slot_timer.sv
// Module: bit, phase and slot counters of the multiplex frame.
// Assumes fsync is a single-clock pulse; last_slot may change only
// together with a frame sync.
module tdm_slot_timer #(
    parameter int WORD_W    = 8,
    parameter int MAX_SLOTS = 128,
    localparam int BW = $clog2(WORD_W),
    localparam int SW = $clog2(MAX_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsync,
    input  logic          dbl_clk,
    input  logic [SW-1:0] last_slot,
    output logic [BW-1:0] bit_cnt,
    output logic [SW-1:0] slot_cnt,
    output logic          sample_en
);

    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

    logic phase;
    logic period_end;

    // A bit period ends every clock, or every second clock in double mode
    always_comb begin
        period_end = !dbl_clk || phase;
        sample_en  = period_end && !fsync;
    end

    // Advance phase, bit and slot counters; frame sync realigns them
    always_ff @(posedge clk) begin
        if (!rst_n || fsync) begin
            phase    <= 1'b0;
            bit_cnt  <= '0;
            slot_cnt <= '0;
        end else if (period_end) begin
            phase <= 1'b0;
            if (bit_cnt == LAST_BIT) begin
                bit_cnt  <= '0;
                slot_cnt <= (slot_cnt >= last_slot) ? '0 : slot_cnt + 1'b1;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end else begin
            phase <= 1'b1;
        end
    end

    // Frame sync lands on bit 0 of slot 0
    p_fsync_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (bit_cnt == '0 && slot_cnt == '0 && !phase));

    // In double mode the first clock of a period leaves the bit count alone
    p_dbl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_clk && !phase && !fsync) |=> (phase && $stable(bit_cnt)));

endmodule

// File: rtl/tdm_slot_map.sv
// Module: decides slot ownership and the local slot index per rate.
// Assumes MAX_SLOTS = 4 * LOCAL_SLOTS, both powers of two.
module tdm_slot_map
    import tdm_pkg::*;
#(
    parameter int LOCAL_SLOTS = 32,
    localparam int MAX_SLOTS = LOCAL_SLOTS * 4,
    localparam int SW = $clog2(MAX_SLOTS),
    localparam int LW = $clog2(LOCAL_SLOTS)
) (
    input  logic [2:0]    rate_bits,
    input  logic [SW-1:0] slot_cnt,
    output logic          slot_sel,
    output logic [LW-1:0] local_idx,
    output logic [SW-1:0] last_slot
);

    rate_e rate;

    // Interleaved ownership: offset taken from the low rate bits
    always_comb begin
        rate = decode_rate(rate_bits);
        unique case (rate)
            RATE_X4: begin
                slot_sel  = (slot_cnt[1:0] == rate_bits[1:0]);
                local_idx = slot_cnt[SW-1:2];
                last_slot = SW'(MAX_SLOTS - 1);
            end
            RATE_X2: begin
                slot_sel  = (slot_cnt[0] == rate_bits[0]);
                local_idx = slot_cnt[SW-2:1];
                last_slot = SW'(2 * LOCAL_SLOTS - 1);
            end
            default: begin
                slot_sel  = 1'b1;
                local_idx = slot_cnt[LW-1:0];
                last_slot = SW'(LOCAL_SLOTS - 1);
            end
        endcase
    end

endmodule

// File: rtl/tdm_rx_shift.sv
// Module: serial-to-parallel conversion for selected slots, MSB first.
// Assumes sample_en marks the sampling clock of each bit period.
module tdm_rx_shift #(
    parameter int WORD_W = 8,
    parameter int LW     = 5,
    localparam int BW = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              slot_sel,
    input  logic [BW-1:0]     bit_cnt,
    input  logic              din,
    input  logic [LW-1:0]     local_idx,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic [LW-1:0]     rx_slot
);

    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

    logic [WORD_W-1:0] shreg;
    logic              take;

    // Bits are taken only at a sample point inside an owned slot
    always_comb take = sample_en && slot_sel;

    // Shift in bits and publish the word after the last one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
            rx_slot  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (take) begin
                shreg <= {shreg[WORD_W-2:0], din};
                if (bit_cnt == LAST_BIT) begin
                    rx_word  <= {shreg[WORD_W-2:0], din};
                    rx_valid <= 1'b1;
                    rx_slot  <= local_idx;
                end
            end
        end
    end

    // A word strobe never lasts two clocks
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // Unselected slots produce no word
    p_no_word_unsel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_sel) |=> !rx_valid);

endmodule

// File: rtl/tdm_mux_port.sv
// Module: top of the TDM multiplex slot interface.
// Ties configuration, frame timing, slot mapping and both data
// directions together. Assumes tx_word is stable during a sent slot.
module tdm_mux_port
    import tdm_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int LOCAL_SLOTS = 32,
    localparam int MAX_SLOTS = LOCAL_SLOTS * 4,
    localparam int BW = $clog2(WORD_W),
    localparam int SW = $clog2(MAX_SLOTS),
    localparam int LW = $clog2(LOCAL_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic              fsync,
    input  logic              mux_in,
    input  logic [WORD_W-1:0] tx_word,
    output logic              mux_out,
    output logic              mux_oe,
    output logic              slot_sel,
    output logic [LW-1:0]     tx_slot,
    output logic [BW-1:0]     bit_cnt,
    output logic [SW-1:0]     slot_cnt,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic [LW-1:0]     rx_slot
);

    port_cfg_t     cfg;
    logic [SW-1:0] last_slot;
    logic          sample_en;
    logic [BW-1:0] tx_idx;
    logic          tx_bit;

    tdm_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    tdm_slot_map #(.LOCAL_SLOTS(LOCAL_SLOTS)) u_map (
        .rate_bits (cfg.rate_bits),
        .slot_cnt  (slot_cnt),
        .slot_sel  (slot_sel),
        .local_idx (tx_slot),
        .last_slot (last_slot)
    );

    tdm_slot_timer #(.WORD_W(WORD_W), .MAX_SLOTS(MAX_SLOTS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .dbl_clk   (cfg.dbl_clk),
        .last_slot (last_slot),
        .bit_cnt   (bit_cnt),
        .slot_cnt  (slot_cnt),
        .sample_en (sample_en)
    );

    tdm_rx_shift #(.WORD_W(WORD_W), .LW(LW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .slot_sel  (slot_sel),
        .bit_cnt   (bit_cnt),
        .din       (mux_in),
        .local_idx (tx_slot),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid),
        .rx_slot   (rx_slot)
    );

    // Pick the transmit bit MSB first and gate the drive enable
    always_comb begin
        tx_idx = BW'(WORD_W - 1) - bit_cnt;
        tx_bit = tx_word[tx_idx];
        mux_oe = slot_sel && !cfg.out_rel;
    end

    // Output line is released whenever the enable is low
    assign mux_out = mux_oe ? tx_bit : 1'bz;

    // Release bit always wins over slot selection
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.out_rel |-> !mux_oe);

    // Drive only inside owned slots
    p_drive_owned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mux_oe |-> slot_sel);

endmodule

// File: tb/tdm_mux_port_tb_top.sv
// Bench: behavioural frame model compared with the port on every clock.
module tdm_mux_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       fsync = 1'b0;
    logic       mux_in = 1'b0;
    logic [7:0] tx_word = 8'h00;
    wire        mux_out;
    logic       mux_oe, slot_sel, rx_valid;
    logic [4:0] tx_slot, rx_slot;
    logic [2:0] bit_cnt;
    logic [6:0] slot_cnt;
    logic [7:0] rx_word;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    // model state
    int m_cfg = 8'h80, m_ph = 0, m_bit = 0, m_slot = 0;
    int m_acc = 0, m_rxv = 0, m_rxw = 0, m_rxs = 0;
    int prev_slot = 0, wraps = 0;

    always #10 clk = ~clk;

    tdm_mux_port dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .fsync(fsync), .mux_in(mux_in), .tx_word(tx_word),
        .mux_out(mux_out), .mux_oe(mux_oe), .slot_sel(slot_sel),
        .tx_slot(tx_slot), .bit_cnt(bit_cnt), .slot_cnt(slot_cnt),
        .rx_word(rx_word), .rx_valid(rx_valid), .rx_slot(rx_slot)
    );

    function automatic int nslots(input int c);
        if (c & 4) return 128;
        if (c & 2) return 64;
        return 32;
    endfunction

    function automatic bit owned(input int c, input int s);
        if (c & 4) return (s % 4) == (c & 3);
        if (c & 2) return (s % 2) == (c & 1);
        return 1'b1;
    endfunction

    function automatic int lidx(input int c, input int s);
        return s / (nslots(c) / 32);
    endfunction

    function automatic string rate_tag(input int c);
        if (c & 4) return "R4";
        if (c & 2) return "R3";
        return "R2";
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d",
                     req, cycles, act, exp);
        end
    endtask

    // Reference model, updated on each rising edge from the old state
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cfg = 8'h80; m_ph = 0; m_bit = 0; m_slot = 0;
            m_acc = 0; m_rxv = 0; m_rxw = 0; m_rxs = 0;
        end else begin
            int adv;
            adv = ((m_cfg & 8) == 0) || (m_ph == 1);
            m_rxv = 0;
            if (!fsync && adv && owned(m_cfg, m_slot)) begin
                m_acc = ((m_acc << 1) | int'(mux_in)) & 8'hFF;
                if (m_bit == 7) begin
                    m_rxv = 1; m_rxw = m_acc; m_rxs = lidx(m_cfg, m_slot);
                end
            end
            if (fsync) begin
                m_ph = 0; m_bit = 0; m_slot = 0;
            end else if (adv) begin
                m_ph = 0;
                if (m_bit == 7) begin
                    m_bit = 0;
                    m_slot = (m_slot >= nslots(m_cfg) - 1) ? 0 : m_slot + 1;
                end else m_bit = m_bit + 1;
            end else m_ph = 1;
            if (cfg_we) m_cfg = int'(cfg_wdata);
        end
    end

    // Compare every clock, mid-cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_sel;
            e_sel = owned(m_cfg, m_slot);
            chk("R5 bit_cnt", int'(bit_cnt), m_bit);
            chk({rate_tag(m_cfg), " slot_cnt"}, int'(slot_cnt), m_slot);
            chk({rate_tag(m_cfg), " slot_sel"}, int'(slot_sel), int'(e_sel));
            if (e_sel) chk({rate_tag(m_cfg), " tx_slot"}, int'(tx_slot), lidx(m_cfg, m_slot));
            chk("R7 rx_valid", int'(rx_valid), m_rxv);
            if (m_rxv != 0) begin
                chk("R7 rx_word", int'(rx_word), m_rxw);
                chk("R7 rx_slot", int'(rx_slot), m_rxs);
            end
            if (m_cfg & 8'h80) chk("R9 mux_oe", int'(mux_oe), 0);
            else chk("R8 mux_oe", int'(mux_oe), int'(e_sel));
            if (e_sel && !(m_cfg & 8'h80))
                chk("R10 mux_out", int'(mux_out), int'(tx_word[7 - m_bit]));
            if (m_slot == 0 && prev_slot == nslots(m_cfg) - 1) wraps++;
            prev_slot = m_slot;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #5;
        mux_in  = 1'($urandom);
        cfg_we  = 1'b0;
        fsync   = 1'b0;
        if (bit_cnt == 3'd0) tx_word = 8'($urandom);
    endtask

    task automatic setup(input logic [7:0] c);
        cfg_we = 1'b1; cfg_wdata = c;
        tick();
        fsync = 1'b1;
        tick();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5;
        // R1: reset state
        chk("R1 bit_cnt", int'(bit_cnt), 0);
        chk("R1 slot_cnt", int'(slot_cnt), 0);
        chk("R1 rx_valid", int'(rx_valid), 0);
        chk("R1 mux_oe", int'(mux_oe), 0);
        rst_n = 1'b1;
        run(20);
        chk("R1 released after reset", int'(mux_oe), 0);

        // R2: 32 slots, single clock
        setup(8'h00);
        wraps = 0;
        run(600);
        chk("R2 frame wraps seen", int'(wraps >= 2), 1);

        // R3: 64 slots, odd slots
        setup(8'h03);
        wraps = 0;
        run(1100);
        chk("R3 frame wraps seen", int'(wraps >= 2), 1);

        // R4: 128 slots, offset 2
        setup(8'h06);
        wraps = 0;
        run(2100);
        chk("R4 frame wraps seen", int'(wraps >= 2), 1);

        // R5: double clock, 64 slots even
        setup(8'h0A);
        run(1200);

        // R6: frame sync in the middle of a slot
        run(13);
        fsync = 1'b1;
        tick();
        chk("R6 bit after sync", int'(bit_cnt), 0);
        chk("R6 slot after sync", int'(slot_cnt), 0);
        run(300);

        // R9: release bit with every slot owned
        setup(8'h80);
        run(300);
        chk("R9 released", int'(mux_oe), 0);

        // R8: 128 slots, offset 0, ignored slots
        setup(8'h04);
        run(700);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule